// File: doc/BRIEF.md
# Slow-Signal Period Deviation Meter

This block times a slow external pulse train against a fast reference clock. A free-running binary timebase counts reference cycles. The slow input is brought into the reference domain through a two-flop synchronizer, and each rising transition takes a snapshot of the timebase. The block subtracts each snapshot from the one before it, which gives the elapsed count for that period. It then reports the signed difference between that count and a programmed nominal count. With a 5 MHz reference and a 0.5 Hz input, the nominal count is 10,000,000.

Each deviation is presented on a valid/ready output so that a logger can collect it. The block also keeps running statistics: a sample count and a signed sum of the accepted deviations. A host can divide the sum by the count to see whether the long-run average period differs from nominal. If a new result arrives while an earlier one has not yet been taken, the new result is discarded and a sticky overrun flag is raised.

Top module: `period_dev_meter`

## Requirements
- R1: The slow input passes through two synchronizing flops and a rising-transition detector. A rise set up before a clock edge makes `dev_valid` go high at the third rising clock edge after that setup, and not earlier.
- R2: The first rising transition after reset only stores its snapshot and produces no sample.
- R3: The timebase is a CNT_W-bit counter that adds one every clock and wraps. The elapsed count is the current snapshot minus the previous snapshot, modulo 2^CNT_W, so a period that spans a counter wrap is measured correctly.
- R4: `dev_value` equals the elapsed count minus the nominal count, as a CNT_W-bit two's complement number.
- R5: The nominal register resets to NOM_DEFAULT. While `nom_wr` is high at a clock edge, the register loads `nom_in`, and later captures use the new value.
- R6: Once `dev_valid` is high, it stays high and `dev_value` stays unchanged until a clock edge at which `dev_ready` is also high. That edge clears `dev_valid`, unless a new sample is loaded at the same edge.
- R7: A capture that arrives while a sample is pending and `dev_ready` is low sets `overrun`, which stays high until cleared. The pending value is kept and the new one is dropped. The dropped capture still becomes the previous snapshot, so the next sample measures only the latest period.
- R8: On every accepted sample, `sample_count` rises by one and `dev_sum` adds the sign-extended deviation. Neither changes otherwise. Both are zero after reset.
- R9: A high `stat_clr` at a clock edge zeroes `sample_count`, `dev_sum` and `overrun`, and takes precedence over any update at the same edge.
- R10: Holding the slow input high for many cycles produces no further capture. Only rising transitions start a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; drives the timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Slow measured signal, asynchronous to clk |
| nom_wr | input | 1 | Load strobe for the nominal count |
| nom_in | input | CNT_W | Nominal count to load |
| stat_clr | input | 1 | Synchronous clear of statistics and overrun |
| dev_ready | input | 1 | Consumer accepts the pending sample |
| dev_valid | output | 1 | A deviation sample is pending |
| dev_value | output | CNT_W | Signed deviation (two's complement) |
| overrun | output | 1 | Sticky: a sample was dropped |
| sample_count | output | SAMP_W | Number of accepted samples |
| dev_sum | output | ACC_W | Signed sum of accepted deviations |

## Verification
The checker assumes that every high and low phase of `sig_in` lasts at least two reference clocks, so that the synchronizer sees each level, and that `dev_ready`, `nom_wr` and `stat_clr` are synchronous to `clk`. The bench drives all inputs on the falling clock edge. It holds the slow input high for at least four cycles and spaces rises at least forty cycles apart. It uses an 8-bit timebase so that many measured periods cross a counter wrap. The nominal count and the deviation sum stay small enough that the expected deviations fit the narrow widths without aliasing.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic {
    CAP_EMPTY = 1'b0,
    CAP_ARMED = 1'b1
  } cap_state_e;

  localparam int unsigned PDM_SYNC_STAGES = 2;
endpackage

// File: rtl/pdm_edge_sync.sv
module pdm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  localparam int unsigned TOP = STAGES;

  // STAGES synchronizing flops plus one history flop for the edge detector
  logic [TOP:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[TOP-1:0], async_in};
  end

  assign rise_o = shreg[TOP-1] & ~shreg[TOP];
endmodule

// File: rtl/pdm_timebase.sv
module pdm_timebase #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/pdm_interval.sv
module pdm_interval
  import pdm_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned NOM_DEFAULT = 10_000_000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] stamp_i,
  input  logic         nom_wr,
  input  logic [W-1:0] nom_in,
  input  logic         stat_clr,
  input  logic         dev_ready,
  output logic         dev_valid,
  output logic [W-1:0] dev_value,
  output logic         overrun,
  output logic         accept_o,
  output logic         drop_o,
  output logic         primed_o
);
  localparam logic [W-1:0] NOM_RST = W'(NOM_DEFAULT);

  function automatic logic [W-1:0] elapsed(input logic [W-1:0] cur, input logic [W-1:0] prv);
    return cur - prv;
  endfunction

  function automatic logic [W-1:0] deviation(input logic [W-1:0] el, input logic [W-1:0] nom);
    return el - nom;
  endfunction

  cap_state_e   st_q;
  logic [W-1:0] prev_q;
  logic [W-1:0] nom_q;
  logic         sample_evt;

  assign sample_evt = cap_i && (st_q == CAP_ARMED);
  assign accept_o   = dev_valid && dev_ready;
  assign drop_o     = sample_evt && dev_valid && !dev_ready;
  assign primed_o   = (st_q == CAP_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nom_q <= NOM_RST;
    else if (nom_wr) nom_q <= nom_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAP_EMPTY;
      prev_q <= '0;
    end else if (cap_i) begin
      st_q   <= CAP_ARMED;
      prev_q <= stamp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_valid <= 1'b0;
      dev_value <= '0;
    end else if (sample_evt && !drop_o) begin
      dev_valid <= 1'b1;
      dev_value <= deviation(elapsed(stamp_i, prev_q), nom_q);
    end else if (accept_o) begin
      dev_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (stat_clr) overrun <= 1'b0;
    else if (drop_o)   overrun <= 1'b1;
  end
endmodule

// File: rtl/pdm_stats.sv
module pdm_stats #(
  parameter int unsigned W      = 32,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned SAMP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [W-1:0]      value_i,
  input  logic              clr_i,
  output logic [SAMP_W-1:0] count_o,
  output logic [ACC_W-1:0]  sum_o
);
  localparam int unsigned EXT = ACC_W - W;

  function automatic logic [ACC_W-1:0] sext(input logic [W-1:0] v);
    return {{EXT{v[W-1]}}, v};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      sum_o   <= '0;
    end else if (clr_i) begin
      count_o <= '0;
      sum_o   <= '0;
    end else if (accept_i) begin
      count_o <= count_o + 1'b1;
      sum_o   <= sum_o + sext(value_i);
    end
  end
endmodule

// File: rtl/period_dev_meter.sv
module period_dev_meter #(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ACC_W       = 48,
  parameter int unsigned SAMP_W      = 32,
  parameter int unsigned NOM_DEFAULT = 10_000_000,
  parameter int unsigned SYNC_STAGES = pdm_pkg::PDM_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sig_in,
  input  logic              nom_wr,
  input  logic [CNT_W-1:0]  nom_in,
  input  logic              stat_clr,
  input  logic              dev_ready,
  output logic              dev_valid,
  output logic [CNT_W-1:0]  dev_value,
  output logic              overrun,
  output logic [SAMP_W-1:0] sample_count,
  output logic [ACC_W-1:0]  dev_sum
);
  // named internal events, observed by the bound checker
  logic             cap_evt;
  logic [CNT_W-1:0] stamp;
  logic             accept;
  logic             drop;
  logic             primed;

  pdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise_o(cap_evt)
  );

  pdm_timebase #(.W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .count_o(stamp)
  );

  pdm_interval #(.W(CNT_W), .NOM_DEFAULT(NOM_DEFAULT)) u_int (
    .clk(clk), .rst_n(rst_n), .cap_i(cap_evt), .stamp_i(stamp),
    .nom_wr(nom_wr), .nom_in(nom_in), .stat_clr(stat_clr),
    .dev_ready(dev_ready), .dev_valid(dev_valid), .dev_value(dev_value),
    .overrun(overrun), .accept_o(accept), .drop_o(drop), .primed_o(primed)
  );

  pdm_stats #(.W(CNT_W), .ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .value_i(dev_value),
    .clr_i(stat_clr), .count_o(sample_count), .sum_o(dev_sum)
  );
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned SAMP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cap_evt,
  input logic              primed,
  input logic              accept,
  input logic              drop,
  input logic              stat_clr,
  input logic              dev_ready,
  input logic              dev_valid,
  input logic [CNT_W-1:0]  dev_value,
  input logic              overrun,
  input logic [SAMP_W-1:0] sample_count,
  input logic [ACC_W-1:0]  dev_sum
);
  logic signed [ACC_W-1:0] ext;
  assign ext = ACC_W'($signed(dev_value));

  // R1: a detected rise lasts a single cycle
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);

  // R2: the arming capture creates no sample
  assert_first_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !primed) |=> !dev_valid);

  // R6: a pending sample holds until taken
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_value)));

  // R7: a dropped capture raises overrun and keeps the old value
  assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !stat_clr) |=> (overrun && $stable(dev_value)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_clr) |=> overrun);

  // R8: statistics advance only on acceptance
  assert_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !stat_clr) |=> (sample_count == $past(sample_count) + 1'b1));

  assert_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !stat_clr) |=> (dev_sum == $past(dev_sum + ext)));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !stat_clr) |=> ($stable(sample_count) && $stable(dev_sum)));

  // R9: clear wins
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr |=> (sample_count == '0 && dev_sum == '0 && !overrun));
endmodule

bind period_dev_meter pdm_checker #(
  .CNT_W(CNT_W), .ACC_W(ACC_W), .SAMP_W(SAMP_W)
) u_pdm_checker (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .primed(primed),
  .accept(accept), .drop(drop), .stat_clr(stat_clr), .dev_ready(dev_ready),
  .dev_valid(dev_valid), .dev_value(dev_value), .overrun(overrun),
  .sample_count(sample_count), .dev_sum(dev_sum)
);

// File: tb/test_period_dev_meter.sv
module test_period_dev_meter;
  localparam int CW = 8;
  localparam int AW = 16;
  localparam int SW = 16;
  localparam int NOM0 = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic          nom_wr = 1'b0;
  logic [CW-1:0] nom_in = '0;
  logic          stat_clr = 1'b0;
  logic          dev_ready = 1'b0;
  logic          dev_valid;
  logic [CW-1:0] dev_value;
  logic          overrun;
  logic [SW-1:0] sample_count;
  logic [AW-1:0] dev_sum;

  always #4 clk = ~clk;

  period_dev_meter #(.CNT_W(CW), .ACC_W(AW), .SAMP_W(SW), .NOM_DEFAULT(NOM0)) i_period_dev_meter (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .nom_wr(nom_wr), .nom_in(nom_in),
    .stat_clr(stat_clr), .dev_ready(dev_ready), .dev_valid(dev_valid),
    .dev_value(dev_value), .overrun(overrun), .sample_count(sample_count),
    .dev_sum(dev_sum)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  int nom_tb = NOM0;
  int last_gap = 0;
  bit primed_tb = 0;
  bit pending_tb = 0;
  logic [CW-1:0] held_val = '0;
  int exp_cnt = 0;
  int exp_sum = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_stats();
    check(int'(sample_count) == exp_cnt, "R8 count", sample_count, exp_cnt);
    check(int'($signed(dev_sum)) == exp_sum, "R8 sum", $signed(dev_sum), exp_sum);
  endtask

  // one rise of sig_in, held high for hi cycles, next rise p cycles later
  task automatic edge_period(input int p, input int hi, input bit take);
    logic [CW-1:0] expv;
    bit had_pending;
    int used;
    had_pending = pending_tb;
    expv = CW'(last_gap - nom_tb);
    sig_in = 1'b1;
    repeat (2) @(negedge clk);
    if (!had_pending) check(dev_valid == 1'b0, "R1 early", dev_valid, 0);
    @(negedge clk);
    if (had_pending) begin
      check(overrun == 1'b1, "R7 overrun", overrun, 1);
      check(dev_value == held_val, "R7 kept", dev_value, held_val);
    end else if (!primed_tb) begin
      check(dev_valid == 1'b0, "R2 first", dev_valid, 0);
    end else begin
      check(dev_valid == 1'b1, "R1 latency", dev_valid, 1);
      check(dev_value == expv, "R3 R4 deviation", $signed(dev_value), $signed(expv));
      held_val = expv;
    end
    used = 3;
    if (primed_tb) begin
      if (take) begin
        dev_ready = 1'b1;
        @(negedge clk);
        dev_ready = 1'b0;
        used = 4;
        exp_cnt++;
        exp_sum += int'($signed(held_val));
        check_stats();
        pending_tb = 0;
      end else begin
        pending_tb = 1;
      end
    end
    repeat (hi - used) @(negedge clk);
    sig_in = 1'b0;
    repeat (p - hi) @(negedge clk);
    if (!pending_tb) check(dev_valid == 1'b0, "R10 no extra capture", dev_valid, 0);
    else begin
      check(dev_valid == 1'b1 && dev_value == held_val, "R6 hold", dev_value, held_val);
      check_stats();
    end
    primed_tb = 1;
    last_gap = p;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(dev_valid == 1'b0, "R6 reset valid", dev_valid, 0);
    check(overrun == 1'b0, "R9 reset overrun", overrun, 0);
    check_stats();

    // R2 arming edge, then sweep around the default nominal (R5), wrapping the 8-bit timebase (R3)
    edge_period(100, 4, 1);
    for (int g = 90; g <= 110; g++) edge_period(g, 4, 1);

    // R5: load a new nominal between rises
    nom_in = CW'(60);
    nom_wr = 1'b1;
    @(negedge clk);
    nom_wr = 1'b0;
    last_gap += 1;
    nom_tb = 60;
    for (int g = 40; g <= 80; g += 5) edge_period(g, 4, 1);

    // R6 hold, then R7 overrun on the next rise
    check(overrun == 1'b0, "R7 idle", overrun, 0);
    edge_period(50, 4, 1);
    edge_period(45, 4, 0);
    edge_period(70, 4, 1);
    edge_period(55, 4, 1);
    check(overrun == 1'b1, "R7 sticky", overrun, 1);

    // R9 clear
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    last_gap += 1;
    exp_cnt = 0;
    exp_sum = 0;
    check(overrun == 1'b0, "R9 overrun", overrun, 0);
    check_stats();

    // R10 long high phase
    edge_period(90, 60, 1);
    edge_period(64, 40, 1);
    edge_period(50, 4, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule